// File: doc/BRIEF.md
# Packed Modulo-31 Lane Inverter

This block computes the multiplicative inverse, modulo the prime 31, of every lane of a packed vector. Each 16-bit lane is first brought to its principal residue. The block then raises it to the power 29 by a fixed chain of four steps. Each step squares the running value and, in three of the four steps, also multiplies by the lane's own residue. For any nonzero residue this yields its inverse. A residue of zero stays zero, and no flag is raised.

The four steps form a four-register pipeline. Every lane of a vector moves through it together, and no lane affects another. Vectors enter and leave on a valid/ready handshake. When the consumer holds off, the whole pipeline freezes and the input stops accepting. With the consumer always ready, one vector is accepted on every clock.

Top module: `modp_lane_inverter`

## Requirements
- R1: For an input lane whose residue r = lane mod 31 is nonzero, the matching output lane equals r^29 mod 31, so (r · out) mod 31 = 1.
- R2: An input lane whose residue is zero yields an output lane of zero.
- R3: An input lane holding any 16-bit value, including 31 and above, is first reduced modulo 31 (for example 31 → 0, 62 → 0, 65535 → 1).
- R4: Every output lane is a principal value in 0..30; bits 15..5 of each lane are zero whenever out_valid is high.
- R5: Lane i occupies bits 16·i+15 down to 16·i on both sides; output lane i depends only on input lane i.
- R6: With out_ready held high, a vector accepted at clock edge n is presented with out_valid high from edge n+3.
- R7: Each accepted vector produces exactly one output transfer, in acceptance order.
- R8: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_data hold their values into the next cycle.
- R9: After synchronous reset, out_valid is low, in_ready is high and out_data is zero.
- R10: Whenever out_valid is low or out_ready is high, in_ready is high, so one vector per clock is accepted when the consumer keeps up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block accepts a vector on this edge |
| in_data | input | 128 | Eight 16-bit lanes to invert |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_data | output | 128 | Eight inverted lanes, each 0..30 |

## Verification
Two things can happen on the same edge: a finished vector leaves while a new one enters, or the consumer stalls while the producer is offering data. Both are provoked by randomizing in_valid and out_ready every cycle, so that acceptance, release and freeze overlap in every combination. A scoreboard keeps the vectors in acceptance order and judges each released vector lane by lane. It also checks that no vector is dropped or duplicated, and that a stalled output keeps its value while in_ready stays low.

// File: rtl/modp_inv_pkg.sv
package modp_inv_pkg;
  // Field characteristic and the width of one residue
  localparam int unsigned PRIME  = 31;
  localparam int unsigned RES_W  = 5;
  localparam int unsigned PROD_W = 2 * RES_W;
  // Addition chain for x^(PRIME-2): each step squares, a set bit also multiplies by x
  // x -> x^3 -> x^7 -> x^14 -> x^29
  localparam int unsigned STAGES = 4;
  localparam logic [STAGES-1:0] STEP_MASK = 4'b1011;
endpackage

// File: rtl/modp_mulred.sv
module modp_mulred
  import modp_inv_pkg::*;
(
  input  logic [RES_W-1:0] a,
  input  logic [RES_W-1:0] b,
  output logic [RES_W-1:0] p
);
  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(a) * PROD_W'(b);
    p    = RES_W'(prod % PROD_W'(PRIME));
  end
endmodule

// File: rtl/modp_chain_stage.sv
module modp_chain_stage
  import modp_inv_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter bit          MUL_X = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   in_v,
  input  logic [LANES*RES_W-1:0] in_x,
  input  logic [LANES*RES_W-1:0] in_y,
  output logic                   out_v,
  output logic [LANES*RES_W-1:0] out_x,
  output logic [LANES*RES_W-1:0] out_y
);
  logic [LANES*RES_W-1:0] next_y;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [RES_W-1:0] sq;
    modp_mulred u_sq (
      .a(in_y[l*RES_W +: RES_W]),
      .b(in_y[l*RES_W +: RES_W]),
      .p(sq)
    );
    if (MUL_X) begin : g_mx
      modp_mulred u_mx (
        .a(sq),
        .b(in_x[l*RES_W +: RES_W]),
        .p(next_y[l*RES_W +: RES_W])
      );
    end else begin : g_sq_only
      assign next_y[l*RES_W +: RES_W] = sq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_x <= '0;
      out_y <= '0;
    end else if (en) begin
      out_v <= in_v;
      out_x <= in_x;
      out_y <= next_y;
    end
  end
endmodule

// File: rtl/modp_lane_inverter.sv
module modp_lane_inverter
  import modp_inv_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*LANE_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int unsigned VEC_W = LANES * RES_W;

  logic             advance;
  logic [STAGES:0]  vld;
  logic [VEC_W-1:0] xs [STAGES+1];
  logic [VEC_W-1:0] ys [STAGES+1];
  logic             unused_x_tail;

  // The whole chain moves together unless a finished vector is being held
  assign advance  = !vld[STAGES] || out_ready;
  assign in_ready = advance;
  assign vld[0]   = in_valid;

  for (genvar l = 0; l < LANES; l++) begin : g_in
    assign xs[0][l*RES_W +: RES_W] =
      RES_W'(in_data[l*LANE_W +: LANE_W] % LANE_W'(PRIME));
  end
  assign ys[0] = xs[0];

  for (genvar s = 0; s < STAGES; s++) begin : g_step
    modp_chain_stage #(
      .LANES(LANES),
      .MUL_X(STEP_MASK[s])
    ) u_stage (
      .clk  (clk),
      .rst  (rst),
      .en   (advance),
      .in_v (vld[s]),
      .in_x (xs[s]),
      .in_y (ys[s]),
      .out_v(vld[s+1]),
      .out_x(xs[s+1]),
      .out_y(ys[s+1])
    );
  end

  assign out_valid = vld[STAGES];
  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign out_data[l*LANE_W +: LANE_W] = LANE_W'(ys[STAGES][l*RES_W +: RES_W]);
  end

  assign unused_x_tail = ^xs[STAGES];
endmodule

// File: rtl/modp_lane_inverter_chk.sv
module modp_lane_inverter_chk
  import modp_inv_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*LANE_W-1:0] out_data
);
  logic [3:0] occ;
  logic       lanes_ok;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + 4'(in_valid && in_ready) - 4'(out_valid && out_ready);
  end

  always_comb begin
    lanes_ok = 1'b1;
    for (int l = 0; l < int'(LANES); l++) begin
      if (out_data[l*LANE_W +: LANE_W] >= LANE_W'(PRIME)) lanes_ok = 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8
  AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready); // R10
  AST_LANE_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lanes_ok); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= 4'(STAGES)); // R7
  AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (occ != 4'd0)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R9
endmodule

bind modp_lane_inverter modp_lane_inverter_chk #(
  .LANES (LANES),
  .LANE_W(LANE_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/modp_lane_inverter_tb_top.sv
module modp_lane_inverter_tb_top;
  localparam int LANES  = 8;
  localparam int LANE_W = 16;
  localparam int W      = LANES * LANE_W;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] src_q[$];
  logic         prev_stall = 1'b0;
  logic [W-1:0] prev_data  = '0;
  logic         saw_out;

  always #4 clk = ~clk;

  modp_lane_inverter #(.LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic int inv_ref(input int raw);
    int r = raw % 31;
    int acc = 1;
    for (int k = 0; k < 29; k++) acc = (acc * r) % 31;
    return (r == 0) ? 0 : acc;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic judge(input logic [W-1:0] src, input logic [W-1:0] res);
    for (int l = 0; l < LANES; l++) begin
      int raw = int'(src[l*LANE_W +: LANE_W]);
      int got = int'(res[l*LANE_W +: LANE_W]);
      int exp = inv_ref(raw);
      // R4: principal value, upper bits clear
      chk(got < 31, "R4 lane range", got, exp);
      if (raw >= 31)           chk(got == exp, "R3 reduced lane", got, exp);
      else if (raw == 0)       chk(got == 0, "R2 zero lane", got, 0);
      else                     chk((raw * got) % 31 == 1, "R1 x*inv==1", (raw * got) % 31, 1);
      // R5: lane position preserved
      chk(got == exp, "R5 lane order/value", got, exp);
    end
  endtask

  // One cycle: drive at negedge, observe settled values, log transfers for the next edge
  task automatic cycle(input logic iv, input logic [W-1:0] id, input logic ordy);
    @(negedge clk);
    in_valid  = iv;
    in_data   = id;
    out_ready = ordy;
    #1;
    saw_out = out_valid;
    if (prev_stall) begin
      chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
      chk(out_data == prev_data, "R8 data held", out_data[31:0], prev_data[31:0]);
    end
    if (out_valid && !out_ready) chk(in_ready == 1'b0, "R8 input blocked", in_ready, 0);
    else                         chk(in_ready == 1'b1, "R10 input open", in_ready, 1);
    if (in_valid && in_ready) src_q.push_back(in_data);
    if (out_valid && out_ready) begin
      if (src_q.size() == 0) chk(1'b0, "R7 extra output", 1, 0);
      else judge(src_q.pop_front(), out_data);
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  endtask

  function automatic logic [W-1:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
    return {16'(a7), 16'(a6), 16'(a5), 16'(a4), 16'(a3), 16'(a2), 16'(a1), 16'(a0)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R9: idle after reset
    chk(out_valid == 1'b0, "R9 out_valid low", out_valid, 0);
    chk(in_ready == 1'b1, "R9 in_ready high", in_ready, 1);
    chk(out_data == '0, "R9 out_data zero", out_data[31:0], 0);

    // R6: latency of an isolated vector
    cycle(1'b1, pack8(1, 2, 3, 4, 5, 6, 7, 8), 1'b1);
    lat = 0;
    do begin
      cycle(1'b0, '0, 1'b1);
      lat++;
    end while (!saw_out && lat < 10);
    chk(lat == 4, "R6 latency", lat, 4);

    // R1: all 30 nonzero residues across lanes; R2 zero; R3 out-of-range lanes
    for (int v = 0; v < 4; v++) begin
      cycle(1'b1, pack8(8*v+1, 8*v+2, 8*v+3, 8*v+4, (8*v+5) % 31, (8*v+6) % 31,
                        (8*v+7) % 31, (8*v+8) % 31), 1'b1);
    end
    cycle(1'b1, '0, 1'b1);
    cycle(1'b1, pack8(31, 62, 65535, 32, 60, 93, 30, 0), 1'b1);
    cycle(1'b1, pack8(0, 30, 0, 1, 0, 15, 0, 16), 1'b1);
    // R8: long stall with a full pipeline and input still offered
    for (int k = 0; k < 6; k++) cycle(1'b1, pack8(k, k+1, k+2, k+3, 9, 10, 11, 12), 1'b0);
    repeat (6) cycle(1'b0, '0, 1'b1);

    // Random mix of acceptance, release and stall
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] d;
      for (int l = 0; l < LANES; l++) begin
        int r = int'($urandom_range(0, 9));
        d[l*LANE_W +: LANE_W] = (r == 0) ? 16'($urandom) : 16'($urandom_range(0, 30));
      end
      cycle(1'(($urandom_range(0, 3)) != 0), d, 1'(($urandom_range(0, 3)) != 0));
    end
    repeat (10) cycle(1'b0, '0, 1'b1);
    // R7: every accepted vector came out exactly once
    chk(src_q.size() == 0, "R7 all delivered", src_q.size(), 0);
    chk(out_valid == 1'b0, "R7 drained", out_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule